// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block runs the setup phase of a single DMA channel, ahead of each work unit. Software programs the channel's registers through a simple write port and then starts the channel by writing the configuration word. Two fields of that word steer the setup. The flow field picks a mode: stop, autobuffer, array, small list or large list. The size field gives the number of 16-bit descriptor elements to read from memory.

In a descriptor mode the sequencer reads the elements one at a time through a request/valid read port. It places each element in the channel register it belongs to, and steps the current-descriptor pointer by one 16-bit word after every read. When the last element has arrived, it sends a one-cycle start pulse to the data-transfer engine. A configuration word read from memory is held back and takes effect only when the whole descriptor has been read. Any register the descriptor does not cover keeps the value it had before.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, every channel register reads zero, and `busy`, `rd_req` and `xfer_start` are low.
- R2: When the block is not busy, an MMR write updates the addressed register. The addresses are: 0 config, 1/2 next-pointer low/high, 3/4 current-pointer low/high, 5/6 start-address low/high, 7 X count, 8 X modify, 9 Y count, 10 Y modify. While busy, MMR writes are ignored, including one that arrives in the same cycle as the last element read.
- R3: A write to the config address starts setup only if no setup has run since reset, or if the stored flow field is 0. Any other config write only stores the new word.
- R4: The flow field is config bits [14:12] and the size field is config bits [11:8]. Setup reads nothing from memory when flow is 0, 1, 2, 3 or 5, or when size is 0. In that case `xfer_start` pulses in the cycle after the config write.
- R5: Element order is 0 next-low, 1 next-high, 2 start-low, 3 start-high, 4 config, 5 X count, 6 X modify, 7 Y count, 8 Y modify. In large-list mode (flow 7), the next pointer is copied into the current pointer and reading begins at element 0.
- R6: Small-list mode (flow 6) also copies next into current, but it skips element 1. The high half of the next pointer then keeps its old value.
- R7: Array mode (flow 4) leaves the current pointer as it is and begins at element 2. The next pointer is not changed.
- R8: Each element is read at the current pointer, and the pointer then grows by 2. At the end it points just past the descriptor.
- R9: The size field limits how many elements are read, and reading always stops after element 8. Registers that are not read keep their values.
- R10: A config element read from memory replaces the config register only after the last element. Until then the config register does not change.
- R11: Only one read is outstanding at a time. `rd_req` is a one-cycle pulse, and the next request waits until `rd_valid` has been seen.
- R12: `busy` is high from the cycle after a fetching config write until the last element is loaded. `xfer_start` pulses once, in the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmr_wr | input | 1 | Register write strobe |
| mmr_addr | input | 4 | Register write address |
| mmr_wdata | input | 16 | Register write data |
| rd_req | output | 1 | Memory read request, one-cycle pulse |
| rd_addr | output | ADDR_W | Byte address of the element being read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| busy | output | 1 | Descriptor fetch in progress |
| cfg_o | output | 16 | Configuration register |
| next_ptr_o | output | ADDR_W | Next-descriptor pointer |
| curr_ptr_o | output | ADDR_W | Current-descriptor pointer |
| start_addr_o | output | ADDR_W | Start address |
| x_count_o | output | 16 | X count |
| x_modify_o | output | 16 | X modify |
| y_count_o | output | 16 | Y count |
| y_modify_o | output | 16 | Y modify |

## Verification
Two events can land in the same cycle: the loading of the final descriptor element, which ends the fetch, and an MMR write from software. The bench provokes this by waiting until `rd_valid` is high for the last element and then driving a Y-modify write into that same clock edge. The write must be dropped, the fetched element must still be loaded, and `xfer_start` must pulse at the next sample point.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    localparam int ELEM_W = 4;
    localparam int N_ELEM = 9;

    // flow field codes
    localparam logic [2:0] FLOW_STOP  = 3'd0;
    localparam logic [2:0] FLOW_ARRAY = 3'd4;
    localparam logic [2:0] FLOW_SMALL = 3'd6;
    localparam logic [2:0] FLOW_LARGE = 3'd7;

    // descriptor element order (fixed; decoded by the loader)
    localparam logic [ELEM_W-1:0] E_NDP_LO = 4'd0;
    localparam logic [ELEM_W-1:0] E_NDP_HI = 4'd1;
    localparam logic [ELEM_W-1:0] E_SA_LO  = 4'd2;
    localparam logic [ELEM_W-1:0] E_SA_HI  = 4'd3;
    localparam logic [ELEM_W-1:0] E_CFG    = 4'd4;
    localparam logic [ELEM_W-1:0] E_XCNT   = 4'd5;
    localparam logic [ELEM_W-1:0] E_XMOD   = 4'd6;
    localparam logic [ELEM_W-1:0] E_YCNT   = 4'd7;
    localparam logic [ELEM_W-1:0] E_YMOD   = 4'd8;
    localparam logic [ELEM_W-1:0] E_LAST   = ELEM_W'(N_ELEM - 1);

    // register write addresses
    localparam logic [3:0] RA_CFG      = 4'd0;
    localparam logic [3:0] RA_NEXT_LO  = 4'd1;
    localparam logic [3:0] RA_NEXT_HI  = 4'd2;
    localparam logic [3:0] RA_CURR_LO  = 4'd3;
    localparam logic [3:0] RA_CURR_HI  = 4'd4;
    localparam logic [3:0] RA_START_LO = 4'd5;
    localparam logic [3:0] RA_START_HI = 4'd6;
    localparam logic [3:0] RA_XCNT     = 4'd7;
    localparam logic [3:0] RA_XMOD     = 4'd8;
    localparam logic [3:0] RA_YCNT     = 4'd9;
    localparam logic [3:0] RA_YMOD     = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } seq_state_e;

endpackage

// File: rtl/dma_elem_order.sv
module dma_elem_order
    import dma_desc_pkg::*;
(
    input  logic [2:0]        flow_i,
    input  logic [ELEM_W-1:0] elem_i,
    output logic              is_desc_o,
    output logic              is_list_o,
    output logic [ELEM_W-1:0] first_o,
    output logic [ELEM_W-1:0] next_o
);

    always_comb begin
        is_list_o = (flow_i == FLOW_SMALL) || (flow_i == FLOW_LARGE);
        is_desc_o = is_list_o || (flow_i == FLOW_ARRAY);
        first_o   = is_list_o ? E_NDP_LO : E_SA_LO;
        if (flow_i == FLOW_SMALL && elem_i == E_NDP_LO) begin
            next_o = E_SA_LO;
        end else begin
            next_o = elem_i + ELEM_W'(1);
        end
    end

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
    import dma_desc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmr_wr,
    input  logic [3:0]        mmr_addr,
    input  logic [15:0]       mmr_wdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data,
    output logic              xfer_start,
    output logic              busy,
    output logic [15:0]       cfg_o,
    output logic [ADDR_W-1:0] next_ptr_o,
    output logic [ADDR_W-1:0] curr_ptr_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [15:0]       x_count_o,
    output logic [15:0]       x_modify_o,
    output logic [15:0]       y_count_o,
    output logic [15:0]       y_modify_o
);

    localparam int HI_W = ADDR_W - 16;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    typedef struct packed {
        seq_state_e        state;
        logic [ELEM_W-1:0] elem;
        logic [ELEM_W-1:0] left;
        logic              run;
        logic              start;
        logic              pend_v;
        logic [15:0]       pend_cfg;
        logic [15:0]       cfg;
        logic [ADDR_W-1:0] next_ptr;
        logic [ADDR_W-1:0] curr_ptr;
        logic [ADDR_W-1:0] start_addr;
        logic [15:0]       xcnt;
        logic [15:0]       xmod;
        logic [15:0]       ycnt;
        logic [15:0]       ymod;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [2:0]        flow_sel;
    logic              ord_desc, ord_list;
    logic [ELEM_W-1:0] ord_first, ord_next;
    logic              startup, last_elem;

    assign flow_sel = (q.state == ST_IDLE) ? mmr_wdata[14:12] : q.cfg[14:12];

    dma_elem_order u_order (
        .flow_i    (flow_sel),
        .elem_i    (q.elem),
        .is_desc_o (ord_desc),
        .is_list_o (ord_list),
        .first_o   (ord_first),
        .next_o    (ord_next)
    );

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        startup   = mmr_wr && (mmr_addr == RA_CFG) && (q.state == ST_IDLE)
                    && (!q.run || q.cfg[14:12] == FLOW_STOP);
        last_elem = (q.left == ELEM_W'(1)) || (q.elem == E_LAST);

        if (q.state == ST_IDLE && mmr_wr) begin
            case (mmr_addr)
                RA_CFG:      d.cfg = mmr_wdata;
                RA_NEXT_LO:  d.next_ptr[15:0] = mmr_wdata;
                RA_NEXT_HI:  d.next_ptr[ADDR_W-1:16] = mmr_wdata[HI_W-1:0];
                RA_CURR_LO:  d.curr_ptr[15:0] = mmr_wdata;
                RA_CURR_HI:  d.curr_ptr[ADDR_W-1:16] = mmr_wdata[HI_W-1:0];
                RA_START_LO: d.start_addr[15:0] = mmr_wdata;
                RA_START_HI: d.start_addr[ADDR_W-1:16] = mmr_wdata[HI_W-1:0];
                RA_XCNT:     d.xcnt = mmr_wdata;
                RA_XMOD:     d.xmod = mmr_wdata;
                RA_YCNT:     d.ycnt = mmr_wdata;
                RA_YMOD:     d.ymod = mmr_wdata;
                default:     ;
            endcase
        end

        if (startup) begin
            d.run    = 1'b1;
            d.pend_v = 1'b0;
            if (ord_desc && mmr_wdata[11:8] != '0) begin
                d.state = ST_REQ;
                d.elem  = ord_first;
                d.left  = mmr_wdata[11:8];
                if (ord_list) begin
                    d.curr_ptr = q.next_ptr;
                end
            end else begin
                d.start = 1'b1;
            end
        end

        case (q.state)
            ST_REQ: d.state = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    case (q.elem)
                        E_NDP_LO: d.next_ptr[15:0] = rd_data;
                        E_NDP_HI: d.next_ptr[ADDR_W-1:16] = rd_data[HI_W-1:0];
                        E_SA_LO:  d.start_addr[15:0] = rd_data;
                        E_SA_HI:  d.start_addr[ADDR_W-1:16] = rd_data[HI_W-1:0];
                        E_CFG: begin
                            d.pend_cfg = rd_data;
                            d.pend_v   = 1'b1;
                        end
                        E_XCNT:   d.xcnt = rd_data;
                        E_XMOD:   d.xmod = rd_data;
                        E_YCNT:   d.ycnt = rd_data;
                        E_YMOD:   d.ymod = rd_data;
                        default:  ;
                    endcase
                    d.curr_ptr = q.curr_ptr + STEP;
                    if (last_elem) begin
                        d.state  = ST_IDLE;
                        d.start  = 1'b1;
                        d.pend_v = 1'b0;
                        if (q.elem == E_CFG) begin
                            d.cfg = rd_data;
                        end else if (q.pend_v) begin
                            d.cfg = q.pend_cfg;
                        end
                    end else begin
                        d.state = ST_REQ;
                        d.elem  = ord_next;
                        d.left  = q.left - ELEM_W'(1);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_req       = (q.state == ST_REQ);
    assign rd_addr      = q.curr_ptr;
    assign busy         = (q.state != ST_IDLE);
    assign xfer_start   = q.start;
    assign cfg_o        = q.cfg;
    assign next_ptr_o   = q.next_ptr;
    assign curr_ptr_o   = q.curr_ptr;
    assign start_addr_o = q.start_addr;
    assign x_count_o    = q.xcnt;
    assign x_modify_o   = q.xmod;
    assign y_count_o    = q.ycnt;
    assign y_modify_o   = q.ymod;

    // R11: a request never repeats in the following cycle
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R11: requests only while the fetch is running
    assert_req_in_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    // R12: the start pulse never overlaps a fetch
    assert_start_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !busy);

    // R12: the end of a fetch is always followed by the start pulse
    assert_end_starts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> xfer_start);

    // R8: each accepted element advances the pointer by one 16-bit word
    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && rd_valid) |=> curr_ptr_o == $past(curr_ptr_o) + STEP);

    // R10: config is frozen while the descriptor is being read
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_o));

endmodule

// File: tb/dma_desc_seq_tb.sv
module dma_desc_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmr_wr = 1'b0;
    logic [3:0]  mmr_addr = '0;
    logic [15:0] mmr_wdata = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        rd_req, xfer_start, busy;
    logic [31:0] rd_addr, next_ptr_o, curr_ptr_o, start_addr_o;
    logic [15:0] cfg_o, x_count_o, x_modify_o, y_count_o, y_modify_o;

    int checks = 0;
    int fails = 0;
    int req_cnt = 0;
    int lat = 1;
    logic [31:0] req_addr [0:15];

    always #2 clk = ~clk;

    dma_desc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mmr_wr(mmr_wr), .mmr_addr(mmr_addr),
        .mmr_wdata(mmr_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_start(xfer_start),
        .busy(busy), .cfg_o(cfg_o), .next_ptr_o(next_ptr_o),
        .curr_ptr_o(curr_ptr_o), .start_addr_o(start_addr_o),
        .x_count_o(x_count_o), .x_modify_o(x_modify_o),
        .y_count_o(y_count_o), .y_modify_o(y_modify_o)
    );

    function automatic logic [15:0] memf(input logic [31:0] a);
        return a[15:0] * 16'd3 + 16'h1111;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // memory responder: one read at a time, data derived from the address
    initial begin
        forever begin
            @(negedge clk);
            while (rst_n && rd_req) begin
                logic [31:0] a;
                a = rd_addr;
                if (req_cnt < 16) req_addr[req_cnt] = a;
                req_cnt++;
                repeat (lat) @(negedge clk);
                rd_valid = 1'b1;
                rd_data  = memf(a);
                @(negedge clk);
                rd_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    task automatic do_reset();
        rst_n = 1'b0;
        mmr_wr = 1'b0;
        lat = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req_cnt = 0;
    endtask

    task automatic mmr_write(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        mmr_wr = 1'b1;
        mmr_addr = a;
        mmr_wdata = v;
        @(negedge clk);
        mmr_wr = 1'b0;
    endtask

    task automatic wait_start(input logic [15:0] cfgw, output bit early, output int reqs);
        int cyc = 0;
        early = 1'b0;
        reqs = 0;
        while (!xfer_start && cyc < 300) begin
            if (busy && cfg_o !== cfgw) early = 1'b1;
            if (rd_req) reqs++;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "rd_req", rd_req, 0);
        chk("R1", "xfer_start", xfer_start, 0);
        chk("R1", "registers", {cfg_o, next_ptr_o, curr_ptr_o, start_addr_o,
            x_count_o, x_modify_o, y_count_o, y_modify_o} == '0, 1);
    endtask

    task automatic t_mmr();
        do_reset();
        for (int i = 1; i <= 10; i++) mmr_write(4'(i), 16'h1000 + 16'(i * 17));
        chk("R2", "next", next_ptr_o, {16'h1022, 16'h1011});
        chk("R2", "curr", curr_ptr_o, {16'h1044, 16'h1033});
        chk("R2", "start", start_addr_o, {16'h1066, 16'h1055});
        chk("R2", "counts", {x_count_o, x_modify_o, y_count_o, y_modify_o},
            {16'h1077, 16'h1088, 16'h1099, 16'h10AA});
        chk("R2", "no start", xfer_start, 0);
    endtask

    task automatic t_nofetch();
        logic [15:0] cf [4] = '{16'h0500, 16'h1500, 16'h2500, 16'h7000};
        for (int i = 0; i < 4; i++) begin
            do_reset();
            mmr_write(4'd1, 16'h0300);
            mmr_write(4'd0, cf[i]);
            chk("R4", $sformatf("start pulse cfg=%h", cf[i]), xfer_start, 1);
            chk("R4", "not busy", busy, 0);
            @(negedge clk);
            chk("R4", "pulse one cycle", xfer_start, 0);
            @(negedge clk);
            chk("R4", "no reads, curr kept", {32'(req_cnt), curr_ptr_o}, 64'd0);
        end
    endtask

    task automatic t_restart();
        do_reset();
        mmr_write(4'd0, 16'h1000);
        chk("R3", "first write starts", xfer_start, 1);
        mmr_write(4'd0, 16'h7300);
        chk("R3", "running write no start", {xfer_start, busy}, 0);
        chk("R3", "stored", cfg_o, 16'h7300);
        mmr_write(4'd0, 16'h0000);
        chk("R3", "stop stored no start", {xfer_start, busy, cfg_o}, 0);
        mmr_write(4'd0, 16'h1000);
        chk("R3", "write after stop starts", xfer_start, 1);
    endtask

    task automatic t_large();
        logic [31:0] p = 32'h0001_0200;
        bit early;
        int reqs;
        do_reset();
        mmr_write(4'd1, p[15:0]);
        mmr_write(4'd2, p[31:16]);
        mmr_write(4'd3, 16'h7777);
        mmr_write(4'd0, 16'h7F5A);
        chk("R12", "busy after write", busy, 1);
        wait_start(16'h7F5A, early, reqs);
        chk("R12", "start seen with busy low", {xfer_start, busy}, 2'b10);
        chk("R9", "clamped to nine reads", req_cnt, 9);
        for (int i = 0; i < 9; i++)
            chk("R5", $sformatf("addr of element %0d", i), req_addr[i], p + 32'(2 * i));
        chk("R5", "next", next_ptr_o, {memf(p + 2), memf(p)});
        chk("R5", "start", start_addr_o, {memf(p + 6), memf(p + 4)});
        chk("R5", "counts", {x_count_o, x_modify_o, y_count_o, y_modify_o},
            {memf(p + 10), memf(p + 12), memf(p + 14), memf(p + 16)});
        chk("R10", "cfg replaced at end", cfg_o, memf(p + 8));
        chk("R10", "cfg held during fetch", early, 0);
        chk("R8", "curr past descriptor", curr_ptr_o, p + 32'd18);
        @(negedge clk);
        chk("R12", "pulse one cycle", xfer_start, 0);
    endtask

    task automatic t_small();
        logic [31:0] p = 32'h0002_0400;
        bit early;
        int reqs;
        do_reset();
        lat = 3;
        mmr_write(4'd10, 16'hBEEF);
        mmr_write(4'd1, p[15:0]);
        mmr_write(4'd2, p[31:16]);
        mmr_write(4'd5, 16'h1234);
        mmr_write(4'd7, 16'h0055);
        mmr_write(4'd0, 16'h6300);
        wait_start(16'h6300, early, reqs);
        chk("R11", "one request per element", reqs, 3);
        chk("R6", "reads", req_cnt, 3);
        chk("R6", "next high kept", next_ptr_o, {p[31:16], memf(p)});
        chk("R6", "start", start_addr_o, {memf(p + 4), memf(p + 2)});
        chk("R9", "unread kept", {x_count_o, y_modify_o, cfg_o}, {16'h0055, 16'hBEEF, 16'h6300});
        chk("R8", "curr", curr_ptr_o, p + 32'd6);
    endtask

    task automatic t_array();
        logic [31:0] c = 32'h0004_0100;
        bit early;
        int reqs;
        do_reset();
        mmr_write(4'd1, 16'h0800);
        mmr_write(4'd2, 16'h0003);
        mmr_write(4'd3, c[15:0]);
        mmr_write(4'd4, c[31:16]);
        mmr_write(4'd0, 16'h4300);
        wait_start(16'h4300, early, reqs);
        chk("R7", "first read at curr", req_addr[0], c);
        chk("R7", "next untouched", next_ptr_o, 32'h0003_0800);
        chk("R7", "start", start_addr_o, {memf(c + 2), memf(c)});
        chk("R7", "cfg from memory", cfg_o, memf(c + 4));
        chk("R8", "curr", curr_ptr_o, c + 32'd6);
    endtask

    task automatic t_collide();
        logic [31:0] c = 32'h0005_0020;
        int guard = 0;
        do_reset();
        mmr_write(4'd3, c[15:0]);
        mmr_write(4'd4, c[31:16]);
        mmr_write(4'd10, 16'h1357);
        mmr_write(4'd0, 16'h4400);
        mmr_write(4'd8, 16'hDEAD);
        chk("R2", "write during fetch ignored", x_modify_o, 16'h0000);
        while (guard < 200) begin
            @(negedge clk);
            #1;
            if (rd_valid && req_cnt == 4) break;
            guard++;
        end
        mmr_wr = 1'b1;
        mmr_addr = 4'd10;
        mmr_wdata = 16'hFFFF;
        @(negedge clk);
        mmr_wr = 1'b0;
        chk("R12", "start with last element", xfer_start, 1);
        chk("R2", "write on last element ignored", y_modify_o, 16'h1357);
        chk("R2", "last element still loaded", x_count_o, memf(c + 6));
    endtask

    initial begin
        t_reset();
        t_mmr();
        t_nofetch();
        t_restart();
        t_large();
        t_small();
        t_array();
        t_collide();
        summary();
    end

endmodule